// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

This block is one channel of a general-purpose timer. A shared prescaler elsewhere on the chip produces a single-cycle tick strobe. On each tick the channel's 32-bit counter steps down by one. The channel expires when a tick arrives while the counter already shows zero, which is an underflow past zero. A loaded value N therefore gives a period of N+1 ticks. On expiry the channel either refills itself from a reload register and keeps running, or it parks at zero and stops until software re-arms it.

Software reaches the channel through three plain write strobes, one each for the control word, the reload value and the counter. It reads the channel back through three plain status buses. None of these carries a data stream, so there is no valid/ready handshake and no back-pressure: every write strobe is accepted in the cycle it is asserted. The control word holds these bits:
- an enable;
- an auto-restart selector;
- a one-shot load command;
- an interrupt enable;
- a sticky pending flag, cleared by writing a one to it;
- a chain bit that is stored but has no effect;
- a debug-halt position that always reads back as zero.

When interrupts are enabled, each expiry also raises a one-cycle pulse on the interrupt output.

Top module: `dtimer_channel`

## Requirements
- R1: Control word bit positions: bit 0 enable, bit 1 restart, bit 2 load, bit 3 interrupt enable, bit 4 pending, bit 5 chain, bit 6 debug-halt. On readback bits 2 and 6 are always 0. Bit 5 reads back as written and does not change counting.
- R2: With the channel running after a load of N, `count_o` drops by one on each tick (N, N-1, ..., 0), and expiry occurs on the (N+1)th tick.
- R3: On expiry with interrupt enable set, the pending bit becomes 1 and `irq_o` is high for exactly the one cycle after the expiring tick's clock edge. With interrupt enable clear, neither happens.
- R4: On expiry with restart set, the counter is refilled from the reload register and counting continues, so expiries repeat every R+1 ticks for a reload value R.
- R5: On expiry with restart clear, the counter stays at 0 and later ticks cause no further expiry until software re-arms the channel.
- R6: A control write with bit 4 set clears the pending flag. A control write with bit 4 clear leaves the pending flag unchanged.
- R7: A control write with bit 2 set copies the reload register into the counter and runs if bit 0 is set. A control write with bit 0 set and bit 2 clear resumes counting from the current counter value.
- R8: A counter write sets `count_o` to the written value, and counting continues from it when the channel is enabled.
- R9: While the enable bit is 0, the counter holds its value and ticks are ignored.
- R10: After reset, the counter, the reload value and the control word are 0 and `irq_o` is low.
- R11: A tick that arrives in the same cycle as a control write or a counter write is ignored. The written state takes effect instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle count strobe from the prescaler |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 7 | Control word write data |
| reload_we_i | input | 1 | Reload register write strobe |
| reload_wdata_i | input | CNT_W | Reload register write data |
| count_we_i | input | 1 | Counter write strobe |
| count_wdata_i | input | CNT_W | Counter write data |
| count_o | output | CNT_W | Current counter value |
| reload_o | output | CNT_W | Current reload value |
| ctrl_o | output | 7 | Control word readback, including the pending flag |
| irq_o | output | 1 | One-cycle interrupt pulse per enabled expiry |

## Verification
The bench sweeps small load values from 0 upward in one-shot and auto-restart modes. This catches off-by-one periods: a design that expired on reaching zero instead of on underflow would pulse one tick early in every case, and a load of 0 would expose it most clearly. After a one-shot expiry the bench keeps ticking, to catch a channel that wraps to all ones and fires again. It also exercises:
- writing zero to bit 4, to catch a pending flag that is not sticky;
- writing all ones to the control word, to catch load or debug-halt bits that read back as set;
- ticks that coincide with a counter write, to catch a channel that decrements the freshly written value in the same cycle.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int unsigned CTRL_W = 7;
  localparam int unsigned EN_B = 0;
  localparam int unsigned RS_B = 1;
  localparam int unsigned LD_B = 2;
  localparam int unsigned IE_B = 3;
  localparam int unsigned PD_B = 4;
  localparam int unsigned CH_B = 5;
  localparam int unsigned DH_B = 6;

  typedef struct packed {
    logic chain;
    logic irq_en;
    logic restart;
    logic enable;
  } ctrl_fields_t;
endpackage

// File: rtl/dtc_ctrl_reg.sv
module dtc_ctrl_reg
  import dtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              expire_i,
  output ctrl_fields_t      fields_o,
  output logic              pend_o,
  output logic [CTRL_W-1:0] word_o
);
  ctrl_fields_t fields_q;
  logic         pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fields_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (we_i) begin
        fields_q.enable  <= wdata_i[EN_B];
        fields_q.restart <= wdata_i[RS_B];
        fields_q.irq_en  <= wdata_i[IE_B];
        fields_q.chain   <= wdata_i[CH_B];
      end
      // a new expiry event wins over a same-cycle clear
      if (expire_i && fields_q.irq_en)
        pend_q <= 1'b1;
      else if (we_i && wdata_i[PD_B])
        pend_q <= 1'b0;
    end
  end

  always_comb begin
    word_o       = '0;
    word_o[EN_B] = fields_q.enable;
    word_o[RS_B] = fields_q.restart;
    word_o[IE_B] = fields_q.irq_en;
    word_o[PD_B] = pend_q;
    word_o[CH_B] = fields_q.chain;
  end

  assign fields_o = fields_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/dtc_down_counter.sv
module dtc_down_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic             restart_i,
  input  logic             ctrl_we_i,
  input  logic             ctrl_wen_i,
  input  logic             ctrl_wload_i,
  input  logic             reload_we_i,
  input  logic [CNT_W-1:0] reload_wdata_i,
  input  logic             count_we_i,
  input  logic [CNT_W-1:0] count_wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rld_q;
  logic             armed_q;
  logic             any_wr;
  logic             step;
  logic             en_eff;

  assign any_wr   = ctrl_we_i | count_we_i;
  assign step     = tick_i & enable_i & armed_q & ~any_wr;
  assign expire_o = step & (cnt_q == ZERO);
  assign en_eff   = ctrl_we_i ? ctrl_wen_i : enable_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld_q <= ZERO;
    end else if (reload_we_i) begin
      rld_q <= reload_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= ZERO;
      armed_q <= 1'b0;
    end else if (count_we_i) begin
      cnt_q   <= count_wdata_i;
      armed_q <= en_eff;
    end else if (ctrl_we_i) begin
      if (ctrl_wload_i) cnt_q <= rld_q;
      armed_q <= ctrl_wen_i;
    end else if (expire_o) begin
      if (restart_i) cnt_q <= rld_q;
      else armed_q <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign count_o  = cnt_q;
  assign reload_o = rld_q;
endmodule

// File: rtl/dtc_irq_pulse.sv
module dtc_irq_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic irq_en_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= expire_i & irq_en_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dtimer_channel.sv
module dtimer_channel
  import dtc_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              reload_we_i,
  input  logic [CNT_W-1:0]  reload_wdata_i,
  input  logic              count_we_i,
  input  logic [CNT_W-1:0]  count_wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              irq_o
);
  ctrl_fields_t fields;
  logic         pend;
  logic         expire;

  dtc_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (ctrl_we_i),
    .wdata_i  (ctrl_wdata_i),
    .expire_i (expire),
    .fields_o (fields),
    .pend_o   (pend),
    .word_o   (ctrl_o)
  );

  dtc_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_i         (tick_i),
    .enable_i       (fields.enable),
    .restart_i      (fields.restart),
    .ctrl_we_i      (ctrl_we_i),
    .ctrl_wen_i     (ctrl_wdata_i[EN_B]),
    .ctrl_wload_i   (ctrl_wdata_i[LD_B]),
    .reload_we_i    (reload_we_i),
    .reload_wdata_i (reload_wdata_i),
    .count_we_i     (count_we_i),
    .count_wdata_i  (count_wdata_i),
    .count_o        (count_o),
    .reload_o       (reload_o),
    .expire_o       (expire)
  );

  dtc_irq_pulse u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire_i (expire),
    .irq_en_i (fields.irq_en),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/dtc_channel_chk.sv
module dtc_channel_chk
  import dtc_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              ctrl_we_i,
  input logic [CTRL_W-1:0] ctrl_wdata_i,
  input logic              count_we_i,
  input logic [CNT_W-1:0]  count_wdata_i,
  input logic [CNT_W-1:0]  count_o,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              irq_o
);
  // R3
  irq_has_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctrl_o[PD_B]);
  // R3
  irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_o[IE_B] |=> !irq_o);
  // R6
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[PD_B] && !(ctrl_we_i && ctrl_wdata_i[PD_B])) |=> ctrl_o[PD_B]);
  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we_i && ctrl_wdata_i[PD_B]) |=> !ctrl_o[PD_B]);
  // R8
  count_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_we_i |=> (count_o == $past(count_wdata_i)));
  // R9
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_o[EN_B] && !ctrl_we_i && !count_we_i) |=> $stable(count_o));
  // R2
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !ctrl_we_i && !count_we_i) |=> $stable(count_o));
endmodule

bind dtimer_channel dtc_channel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_i        (tick_i),
  .ctrl_we_i     (ctrl_we_i),
  .ctrl_wdata_i  (ctrl_wdata_i),
  .count_we_i    (count_we_i),
  .count_wdata_i (count_wdata_i),
  .count_o       (count_o),
  .ctrl_o        (ctrl_o),
  .irq_o         (irq_o)
);

// File: tb/dtimer_channel_tb_top.sv
module dtimer_channel_tb_top;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_i = 1'b0;
  logic         ctrl_we_i = 1'b0;
  logic [6:0]   ctrl_wdata_i = '0;
  logic         reload_we_i = 1'b0;
  logic [W-1:0] reload_wdata_i = '0;
  logic         count_we_i = 1'b0;
  logic [W-1:0] count_wdata_i = '0;
  logic [W-1:0] count_o;
  logic [W-1:0] reload_o;
  logic [6:0]   ctrl_o;
  logic         irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dtimer_channel #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .reload_we_i(reload_we_i), .reload_wdata_i(reload_wdata_i),
    .count_we_i(count_we_i), .count_wdata_i(count_wdata_i),
    .count_o(count_o), .reload_o(reload_o), .ctrl_o(ctrl_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [6:0] v);
    @(negedge clk); ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk); ctrl_we_i = 1'b0;
  endtask

  task automatic wr_reload(input logic [W-1:0] v);
    @(negedge clk); reload_we_i = 1'b1; reload_wdata_i = v;
    @(negedge clk); reload_we_i = 1'b0;
  endtask

  task automatic wr_count(input logic [W-1:0] v);
    @(negedge clk); count_we_i = 1'b1; count_wdata_i = v;
    @(negedge clk); count_we_i = 1'b0;
  endtask

  // one tick; outputs sampled at the following falling edge
  task automatic one_tick();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(count_o == 0, "R10 count", count_o, 0);
    chk(reload_o == 0, "R10 reload", reload_o, 0);
    chk(ctrl_o == 0, "R10 ctrl", W'(ctrl_o), 0);
    chk(irq_o == 1'b0, "R10 irq", W'(irq_o), 0);

    // R2 R3 R5: one-shot sweep, loads 0..5
    for (int n = 0; n <= 5; n++) begin
      wr_reload(W'(n));
      wr_ctrl(7'h1D);  // enable, load, irq enable, clear pending
      chk(count_o == W'(n), "R7 load copies reload", count_o, W'(n));
      chk(ctrl_o == 7'h09, "R1 readback after load", W'(ctrl_o), W'(7'h09));
      for (int k = 1; k <= n + 3; k++) begin
        logic [W-1:0] ec;
        bit ei;
        one_tick();
        ec = (k <= n) ? W'(n - k) : '0;
        ei = (k == n + 1);
        chk(count_o == ec, "R2 count", count_o, ec);
        chk(irq_o == ei, "R3 R5 irq at underflow", W'(irq_o), W'(ei));
        if (ei) begin
          chk(ctrl_o[4] == 1'b1, "R3 pending set", W'(ctrl_o[4]), 1);
          @(negedge clk);
          chk(irq_o == 1'b0, "R3 single-cycle irq", W'(irq_o), 0);
        end
      end
    end

    // R6 pending sticky then write-one-clear
    wr_ctrl(7'h09);
    chk(ctrl_o[4] == 1'b1, "R6 zero write keeps pending", W'(ctrl_o[4]), 1);
    wr_ctrl(7'h18);
    chk(ctrl_o[4] == 1'b0, "R6 one write clears pending", W'(ctrl_o[4]), 0);

    // R4 restart sweep, reloads 0..3
    for (int r = 0; r <= 3; r++) begin
      int pulses;
      pulses = 0;
      wr_reload(W'(r));
      wr_ctrl(7'h1F);  // enable, restart, load, irq enable, clear pending
      for (int k = 1; k <= 3 * (r + 1); k++) begin
        logic [W-1:0] ec;
        bit ei;
        one_tick();
        ec = W'(r - (k % (r + 1)));
        ei = ((k % (r + 1)) == 0);
        if (irq_o) pulses++;
        chk(count_o == ec, "R4 periodic count", count_o, ec);
        chk(irq_o == ei, "R4 periodic irq", W'(irq_o), W'(ei));
      end
      chk(pulses == 3, "R4 pulse total", W'(pulses), 3);
    end

    // R3 irq enable clear: expiry gives no pulse and no pending
    wr_reload(W'(1));
    wr_ctrl(7'h15);  // enable, load, clear pending; irq enable off
    for (int k = 1; k <= 3; k++) begin
      one_tick();
      chk(irq_o == 1'b0, "R3 no irq when disabled", W'(irq_o), 0);
    end
    chk(ctrl_o[4] == 1'b0, "R3 no pending when disabled", W'(ctrl_o[4]), 0);

    // R9 R7: hold while disabled, resume without load
    wr_reload(W'(10));
    wr_ctrl(7'h05);
    repeat (3) one_tick();
    chk(count_o == 7, "R2 count after 3", count_o, 7);
    wr_ctrl(7'h00);
    repeat (4) one_tick();
    chk(count_o == 7, "R9 ticks ignored while disabled", count_o, 7);
    wr_ctrl(7'h01);
    chk(count_o == 7, "R7 enable keeps count", count_o, 7);
    repeat (2) one_tick();
    chk(count_o == 5, "R7 resume from current", count_o, 5);

    // R8 counter write
    wr_count('1);
    chk(count_o == '1, "R8 counter write", count_o, '1);
    one_tick();
    chk(count_o == {{(W-1){1'b1}}, 1'b0}, "R8 count from written",
        count_o, {{(W-1){1'b1}}, 1'b0});

    // R11 tick coincides with counter write
    @(negedge clk); count_we_i = 1'b1; count_wdata_i = W'(20); tick_i = 1'b1;
    @(negedge clk); count_we_i = 1'b0; tick_i = 1'b0;
    chk(count_o == 20, "R11 tick during write ignored", count_o, 20);

    // R1 all-ones write readback; chain has no effect on the period
    wr_reload(W'(2));
    wr_ctrl(7'h7F);
    chk(ctrl_o == 7'h2B, "R1 load and halt read zero", W'(ctrl_o), W'(7'h2B));
    wr_ctrl(7'h3D);  // chain, irq enable, load, enable, clear pending
    for (int k = 1; k <= 3; k++) begin
      one_tick();
      chk(irq_o == (k == 3), "R1 chain no effect", W'(irq_o), W'(k == 3));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule